// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Unit

This unit lets any core of a cluster of up to four cores interrupt another core and leave it short messages. Cores write 64-bit command words to a shared register port. An interrupt-send command sets one bit in the target core's 32-bit interrupt status register. A mail-send or generic-send command places a 32-bit payload into one of the target core's four mailbox words. A byte mask in the command selects which bytes of the old word are kept.

Each core has a register block. The block holds that core's status register, an interrupt enable register, a write-one-to-clear register and the four mailbox words. A core's interrupt line is high while any status bit with a matching enable bit is set. Reads return one 32-bit register one cycle after the read is requested.

Command word layout:
- Bits 63:32 carry the payload.
- Bits 30:27 carry the keep mask.
- Bits 25:16 carry the target core.
- Bits 15:0 carry the vector or address field.

Per-core register block, at 0x1000 + core*0x100:
- Status at +0x00, read only.
- Enable at +0x04, read and write.
- Clear at +0x0C, write only.
- Mailbox word k at +0x20 + 4*k.

Top module: `ipi_mbox_unit`

## Requirements
- R1: After reset, every status, enable and mailbox register reads zero and all `irq_o` bits are low.
- R2: A write to address 0x0040 is an interrupt send. It is accepted at any width. It sets bit `wr_data_i[4:0]` of the status register of core `wr_data_i[25:16]` and leaves the other bits and the other cores unchanged.
- R3: `irq_o[c]` is high in the cycle after any write that leaves core c with a status bit set whose enable bit is also set. It is low when no such bit exists.
- R4: A write to a core's clear register at +0x0C clears exactly the status bits that are 1 in `wr_data_i[31:0]`.
- R5: A full-width write to 0x0048 is a mail send. It targets the mailbox word at byte address 0x1020 + (`wr_data_i` & 0x1C) of core `wr_data_i[25:16]`. With the keep mask `wr_data_i[30:27]` at zero, that word becomes `wr_data_i[63:32]`. A slot field `wr_data_i[4:2]` of 4 or more selects no word, and the command is dropped.
- R6: Keep-mask bit i set preserves byte i of the addressed mailbox word. Keep-mask bit i clear replaces byte i from the payload. All four bits set leaves the word unchanged.
- R7: A full-width write to 0x0158 is a generic send. It uses `wr_data_i[15:0]` as the target byte address within the core block. It performs the same masked mailbox write when that address is 0x1020, 0x1024, 0x1028 or 0x102C. Any other address drops the command.
- R8: A mail send or generic send with `wr_full_i` low changes no state.
- R9: Any send whose target core field is NUM_CORES or greater changes no state and raises no interrupt.
- R10: A read is requested by `rd_en_i` at a clock edge. It updates `rd_data_o` at that edge with the register at `rd_addr_i`. Unmapped addresses read zero. `rd_data_o` holds its value while `rd_en_i` is low.
- R11: A write to a core's enable register at +0x04 stores `wr_data_i[31:0]`, and the value reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 16 | Write byte address |
| wr_data_i | input | 64 | Write data or command word |
| wr_full_i | input | 1 | High when the write is a full 64-bit access |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 16 | Read byte address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | NUM_CORES | Per-core interrupt line |

## Verification
Interrupt sends are tried with the lowest vector, a middle vector and the highest vector. This shows that the vector-to-bit decode is neither shifted nor truncated. Mailbox sends are tried with four keep masks:
- A zero mask, for a whole-word write.
- An alternating mask, which tells preserved bytes from replaced ones and catches reversed polarity or byte order.
- An all-ones mask, for no change.
- A mask on an already written word, which shows the merge reads the old value.

The same payloads are also sent through rejected paths: a narrow width, an out-of-range core, an out-of-range slot and a non-mailbox generic address. These separate the acceptance conditions from the write logic itself.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned MAX_CORES = 4;
  localparam int unsigned MBOX_N    = 4;
  localparam int unsigned CORE_W    = $clog2(MAX_CORES);
  localparam int unsigned SLOT_W    = $clog2(MBOX_N);

  localparam logic [15:0] OFF_IPI  = 16'h0040;
  localparam logic [15:0] OFF_MAIL = 16'h0048;
  localparam logic [15:0] OFF_ANY  = 16'h0158;
  localparam logic [5:0]  BLK_TAG  = 6'b000100;  // 0x1000..0x13FF
  localparam logic [7:0]  REG_ST   = 8'h00;
  localparam logic [7:0]  REG_EN   = 8'h04;
  localparam logic [7:0]  REG_CLR  = 8'h0C;
  localparam logic [3:0]  REG_MBX  = 4'h2;

  typedef struct packed {
    logic              set_v;
    logic              mbox_v;
    logic              en_v;
    logic              clr_v;
    logic [CORE_W-1:0] core;
    logic [4:0]        vec;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        keep;
    logic [31:0]       data;
  } ipi_act_t;

  function automatic logic [31:0] merge_word(logic [31:0] old_w, logic [31:0] new_w,
                                              logic [3:0] keep);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = keep[i] ? old_w[i*8 +: 8] : new_w[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic        wr_en_i,
  input  logic [15:0] wr_addr_i,
  input  logic [63:0] wr_data_i,
  input  logic        wr_full_i,
  output ipi_act_t    act_o
);
  logic [9:0] tgt;
  logic       tgt_ok;
  logic       any_hit;

  assign tgt     = wr_data_i[25:16];
  assign tgt_ok  = 32'(tgt) < NUM_CORES;
  assign any_hit = (wr_data_i[15:4] == 12'h102) && (wr_data_i[1:0] == 2'b00);

  always_comb begin
    act_o      = '0;
    act_o.core = tgt[CORE_W-1:0];
    act_o.vec  = wr_data_i[4:0];
    act_o.slot = wr_data_i[3:2];
    act_o.keep = wr_data_i[30:27];
    act_o.data = wr_data_i[63:32];
    if (wr_en_i) begin
      if (wr_addr_i == OFF_IPI) begin
        act_o.set_v = tgt_ok;
      end else if (wr_addr_i == OFF_MAIL) begin
        act_o.mbox_v = wr_full_i && tgt_ok && !wr_data_i[4];
      end else if (wr_addr_i == OFF_ANY) begin
        act_o.mbox_v = wr_full_i && tgt_ok && any_hit;
      end else if (wr_addr_i[15:10] == BLK_TAG && 32'(wr_addr_i[9:8]) < NUM_CORES) begin
        act_o.core  = wr_addr_i[9:8];
        act_o.data  = wr_data_i[31:0];
        act_o.en_v  = wr_addr_i[7:0] == REG_EN;
        act_o.clr_v = wr_addr_i[7:0] == REG_CLR;
      end
    end
  end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
#(
  parameter int unsigned CORE_ID = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  ipi_act_t               act_i,
  output logic [31:0]            status_o,
  output logic [31:0]            enable_o,
  output logic [MBOX_N-1:0][31:0] mbox_o,
  output logic                   irq_o
);
  logic hit;
  assign hit = act_i.core == CORE_W'(CORE_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else if (hit) begin
      if (act_i.set_v)      status_o <= status_o | (32'h1 << act_i.vec);
      else if (act_i.clr_v) status_o <= status_o & ~act_i.data;
      if (act_i.en_v)       enable_o <= act_i.data;
    end
  end

  for (genvar w = 0; w < MBOX_N; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mbox_o[w] <= '0;
      else if (hit && act_i.mbox_v && act_i.slot == SLOT_W'(w))
        mbox_o[w] <= merge_word(mbox_o[w], act_i.data, act_i.keep);
    end
  end

  assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/ipi_rd_port.sv
module ipi_rd_port
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  rd_en_i,
  input  logic [15:0]                           rd_addr_i,
  input  logic [NUM_CORES-1:0][31:0]            status_i,
  input  logic [NUM_CORES-1:0][31:0]            enable_i,
  input  logic [NUM_CORES-1:0][MBOX_N-1:0][31:0] mbox_i,
  output logic [31:0]                           rd_data_o
);
  logic [CORE_W-1:0] core;
  logic [7:0]        reg_off;
  logic              in_blk;
  logic [31:0]       rd_next;

  assign core    = rd_addr_i[9:8];
  assign reg_off = rd_addr_i[7:0];
  assign in_blk  = rd_addr_i[15:10] == BLK_TAG && 32'(core) < NUM_CORES;

  always_comb begin
    rd_next = '0;
    if (in_blk) begin
      if (reg_off == REG_ST)      rd_next = status_i[core];
      else if (reg_off == REG_EN) rd_next = enable_i[core];
      else if (reg_off[7:4] == REG_MBX && reg_off[1:0] == 2'b00)
        rd_next = mbox_i[core][reg_off[3:2]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_next;
  end
endmodule

// File: rtl/ipi_mbox_unit.sv
module ipi_mbox_unit
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [15:0]          wr_addr_i,
  input  logic [63:0]          wr_data_i,
  input  logic                 wr_full_i,
  input  logic                 rd_en_i,
  input  logic [15:0]          rd_addr_i,
  output logic [31:0]          rd_data_o,
  output logic [NUM_CORES-1:0] irq_o
);
  ipi_act_t                               act;
  logic [NUM_CORES-1:0][31:0]             status;
  logic [NUM_CORES-1:0][31:0]             enable;
  logic [NUM_CORES-1:0][MBOX_N-1:0][31:0] mbox;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) dec_i (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_full_i(wr_full_i),
    .act_o    (act)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_core_slot #(.CORE_ID(c)) slot_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act),
      .status_o(status[c]),
      .enable_o(enable[c]),
      .mbox_o  (mbox[c]),
      .irq_o   (irq_o[c])
    );
  end

  ipi_rd_port #(.NUM_CORES(NUM_CORES)) rd_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .status_i (status),
    .enable_i (enable),
    .mbox_i   (mbox),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/ipi_mbox_chk.sv
module ipi_mbox_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  wr_en_i,
  input logic [15:0]                           wr_addr_i,
  input logic [63:0]                           wr_data_i,
  input logic                                  wr_full_i,
  input logic [NUM_CORES-1:0]                  irq_o,
  input logic [NUM_CORES-1:0][31:0]            status,
  input logic [NUM_CORES-1:0][31:0]            enable,
  input logic [NUM_CORES-1:0][MBOX_N-1:0][31:0] mbox
);
  logic ipi_wr;
  logic narrow_send;
  assign ipi_wr      = wr_en_i && wr_addr_i == OFF_IPI;
  assign narrow_send = wr_en_i && !wr_full_i && (wr_addr_i == OFF_MAIL || wr_addr_i == OFF_ANY);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (irq_o == '0 && status == '0));

  // R9
  bad_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipi_wr && 32'(wr_data_i[25:16]) >= NUM_CORES) |=> $stable(status));

  // R8
  narrow_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_send |=> $stable(mbox));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    // R2
    set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ipi_wr && 32'(wr_data_i[25:16]) == c) |=> status[c][$past(wr_data_i[4:0])]);
    // R3
    irq_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ipi_wr && 32'(wr_data_i[25:16]) == c && enable[c][wr_data_i[4:0]]) |=> irq_o[c]);
    // R4
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 16'(16'h1000 + c * 16'h100 + 16'h0C))
      |=> (status[c] & $past(wr_data_i[31:0])) == '0);
  end
endmodule

bind ipi_mbox_unit ipi_mbox_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wr_full_i(wr_full_i),
  .irq_o    (irq_o),
  .status   (status),
  .enable   (enable),
  .mbox     (mbox)
);

// File: tb/ipi_mbox_unit_tb_top.sv
module ipi_mbox_unit_tb_top;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [15:0]   wr_addr_i = '0;
  logic [63:0]   wr_data_i = '0;
  logic          wr_full_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [15:0]   rd_addr_i = '0;
  logic [31:0]   rd_data_o;
  logic [NC-1:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipi_mbox_unit #(.NUM_CORES(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_full_i(wr_full_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] cmd(logic [9:0] core, logic [3:0] keep,
                                      logic [15:0] low, logic [31:0] pay);
    return {pay, 1'b0, keep, 1'b0, core, low};
  endfunction

  function automatic logic [15:0] reg_a(int core, int off);
    return 16'(32'h1000 + core * 32'h100 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d, logic full);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_full_i = full;
    @(negedge clk);
    wr_en_i = 1'b0; wr_full_i = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(reg_a(c, 0), v);    chk("R1 status", v, 0);
      rd(reg_a(c, 4), v);    chk("R1 enable", v, 0);
      rd(reg_a(c, 'h2C), v); chk("R1 mbox", v, 0);
    end
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_ipi();
    logic [31:0] v;
    wr(16'h0040, cmd(10'd1, 4'h0, 16'd5, 32'h0), 1'b0);
    rd(reg_a(1, 0), v); chk("R2 vec5", v, 32'h20);
    rd(reg_a(0, 0), v); chk("R2 other core", v, 0);
    chk("R3 masked irq", 32'(irq_o), 0);
    wr(reg_a(1, 4), 64'h20, 1'b0);
    rd(reg_a(1, 4), v); chk("R11 enable rb", v, 32'h20);
    chk("R3 irq high", 32'(irq_o), 32'h2);
    wr(reg_a(1, 'hC), 64'h20, 1'b0);
    rd(reg_a(1, 0), v); chk("R4 clear all", v, 0);
    chk("R3 irq low", 32'(irq_o), 0);
    wr(16'h0040, cmd(10'd1, 4'h0, 16'd0, 32'h0), 1'b1);
    wr(16'h0040, cmd(10'd1, 4'h0, 16'd31, 32'h0), 1'b0);
    rd(reg_a(1, 0), v); chk("R2 vec0 vec31", v, 32'h8000_0001);
    wr(reg_a(1, 'hC), 64'h1, 1'b0);
    rd(reg_a(1, 0), v); chk("R4 partial clear", v, 32'h8000_0000);
  endtask

  task automatic t_bad_core();
    logic [31:0] v;
    wr(16'h0040, cmd(10'd4, 4'h0, 16'd3, 32'h0), 1'b0);
    wr(16'h0040, cmd(10'h3FF, 4'h0, 16'd3, 32'h0), 1'b0);
    wr(16'h0048, cmd(10'd4, 4'h0, 16'h0, 32'h1234_5678), 1'b1);
    rd(reg_a(0, 0), v);    chk("R9 core0 status", v, 0);
    rd(reg_a(1, 0), v);    chk("R9 core1 status", v, 32'h8000_0000);
    rd(reg_a(3, 0), v);    chk("R9 core3 status", v, 0);
    rd(reg_a(0, 'h20), v); chk("R9 mbox", v, 0);
    chk("R9 irq", 32'(irq_o), 0);
  endtask

  task automatic t_mail();
    logic [31:0] v;
    wr(16'h0048, cmd(10'd2, 4'h0, 16'h4, 32'hA1B2_C3D4), 1'b1);
    rd(reg_a(2, 'h24), v); chk("R5 full word", v, 32'hA1B2_C3D4);
    rd(reg_a(2, 'h20), v); chk("R5 neighbour", v, 0);
    wr(16'h0048, cmd(10'd2, 4'h5, 16'h4, 32'h1122_3344), 1'b1);
    rd(reg_a(2, 'h24), v); chk("R6 keep 0101", v, 32'h11B2_33D4);
    wr(16'h0048, cmd(10'd2, 4'hF, 16'h4, 32'hFFFF_FFFF), 1'b1);
    rd(reg_a(2, 'h24), v); chk("R6 keep all", v, 32'h11B2_33D4);
    wr(16'h0048, cmd(10'd2, 4'h0, 16'h4, 32'hFFFF_FFFF), 1'b0);
    rd(reg_a(2, 'h24), v); chk("R8 narrow mail", v, 32'h11B2_33D4);
    wr(16'h0048, cmd(10'd0, 4'h0, 16'hC, 32'h0000_0077), 1'b1);
    rd(reg_a(0, 'h2C), v); chk("R5 slot3", v, 32'h77);
    wr(16'h0048, cmd(10'd0, 4'h0, 16'h14, 32'hDEAD_0000), 1'b1);
    for (int k = 0; k < 3; k++) begin
      rd(reg_a(0, 'h20 + 4 * k), v); chk("R5 slot5 dropped", v, 0);
    end
    rd(reg_a(0, 'h2C), v); chk("R5 slot5 dropped", v, 32'h77);
  endtask

  task automatic t_any();
    logic [31:0] v;
    wr(16'h0158, cmd(10'd3, 4'h0, 16'h102C, 32'hDEAD_BEEF), 1'b1);
    rd(reg_a(3, 'h2C), v); chk("R7 generic", v, 32'hDEAD_BEEF);
    wr(16'h0158, cmd(10'd3, 4'h8, 16'h102C, 32'h0000_0000), 1'b1);
    rd(reg_a(3, 'h2C), v); chk("R7 generic keep", v, 32'hDE00_0000);
    wr(16'h0158, cmd(10'd3, 4'h0, 16'h1004, 32'h0000_0055), 1'b1);
    rd(reg_a(3, 4), v);    chk("R7 non-mbox enable", v, 0);
    rd(reg_a(3, 0), v);    chk("R7 non-mbox status", v, 0);
    rd(reg_a(3, 'h2C), v); chk("R7 non-mbox mbox", v, 32'hDE00_0000);
    wr(16'h0158, cmd(10'd2, 4'h0, 16'h1024, 32'h0), 1'b0);
    rd(reg_a(2, 'h24), v); chk("R8 narrow generic", v, 32'h11B2_33D4);
  endtask

  task automatic t_read();
    logic [31:0] v;
    rd(reg_a(3, 'h2C), v);
    @(negedge clk);
    rd_addr_i = 16'h0000;
    @(negedge clk);
    chk("R10 hold", rd_data_o, 32'hDE00_0000);
    rd(16'h2000, v);      chk("R10 unmapped", v, 0);
    rd(reg_a(1, 8), v);   chk("R10 hole", v, 0);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = reg_a(1, 0);
    @(posedge clk); #1;
    chk("R10 one cycle", rd_data_o, 32'h8000_0000);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_ni = 1'b1;
    t_reset();
    t_ipi();
    t_bad_core();
    t_mail();
    t_any();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule